// File: doc/BRIEF.md
# Program Breakpoint Control and Status Unit

This unit watches the instruction stream of a processor core for debug halt conditions. It holds three program-address breakpoint registers and one register that serves either as an extra exact-address breakpoint or as an address mask. It also holds a break control word and a sticky break status word. A debug host reaches all of these through a small register bus.

Every cycle the unit checks the fetch address and opcode against the enabled conditions. It also takes a change-of-flow indication and a host force-break pulse. When a condition hits while the core is running, the unit emits a single-cycle break request and enters the halted state. It then records every cause that hit in that cycle. While halted it ignores further hits. A run request clears the halt and the status. The core pipeline, the act of stopping it and the serial debug port are outside this block.

Top module: `bpu_top`

## Requirements
- R1: Register addresses 0, 1, 2 and 3 hold program breakpoint A, program breakpoint B, the mask/standalone register and program breakpoint D. A write with reg_we stores all 16 bits at the clock edge. Reads through reg_rdata are combinational. Any address other than 0 to 3, 8 and 9 reads as zero.
- R2: Address 8 is the control word, and control bits 1 and 0 always read as 0. Control bit 15 keeps timers running while halted: timers_run equals (not halted) or control bit 15.
- R3: Address 9 is the status word and cannot be written. Status bits 15 to 8 and bit 2 always read as 0.
- R4: When fetch_valid is high and the fetch address matches breakpoint A, a break occurs if control bit 12 is set, and status bit 6 is set. Breakpoint B works the same way with control bit 11 and status bit 5.
- R5: With control bit 10 set, a valid fetch whose address equals register 2 exactly causes a break and sets status bit 4.
- R6: With control bit 9 set, every address bit that is 1 in register 2 is ignored when comparing against breakpoints A, B and D.
- R7: Breakpoint D is active only when control bits 7, 4 and 3 are all 1. Its hit sets status bit 3.
- R8: With control bit 13 set, a flow_chg pulse causes a break and sets status bit 7, whether or not fetch_valid is high.
- R9: A force_brk pulse always causes a break and sets status bit 1. A valid fetch of opcode 0x9598 always causes a break and sets status bit 0.
- R10: A hit while running gives brk_req high for exactly one cycle, in the cycle after the hit. In that same cycle halted goes high, and all causes that hit together are recorded.
- R11: While halted, new hits produce no brk_req and leave the status word unchanged.
- R12: A run_req while halted clears halted and every status bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register bus write strobe |
| reg_addr | input | 4 | Register bus address |
| reg_wdata | input | DW | Register bus write data |
| reg_rdata | output | DW | Register bus read data (combinational) |
| fetch_valid | input | 1 | Fetch address and opcode are valid this cycle |
| fetch_pc | input | DW | Fetch address |
| fetch_op | input | 16 | Fetched opcode |
| flow_chg | input | 1 | Program flow changed this cycle |
| force_brk | input | 1 | Host force-break pulse |
| run_req | input | 1 | Resume request |
| brk_req | output | 1 | Single-cycle break request |
| halted | output | 1 | Core is held in break |
| timers_run | output | 1 | Timers may count |

## Verification
A wrong comparator or enable decode shows at the ports one cycle after the fetch, as a missing or spurious brk_req. On the next status read it shows as a wrong cause bit. A corrupted halt flag shows in the same cycle on halted and timers_run, and again at the following hit: a second pulse, or no pulse at all. Status that is not properly sticky or cleared shows on the first read of address 9 after a halted-cycle hit or after a run request.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    localparam logic [3:0] ADDR_BPA  = 4'h0;
    localparam logic [3:0] ADDR_BPB  = 4'h1;
    localparam logic [3:0] ADDR_MSK  = 4'h2;
    localparam logic [3:0] ADDR_BPD  = 4'h3;
    localparam logic [3:0] ADDR_CTRL = 4'h8;
    localparam logic [3:0] ADDR_STS  = 4'h9;

    localparam int C_TIMERS = 15;
    localparam int C_FLOW   = 13;
    localparam int C_EN_A   = 12;
    localparam int C_EN_B   = 11;
    localparam int C_EN_S   = 10;
    localparam int C_MASK   = 9;
    localparam int C_D_X    = 7;
    localparam int C_D_Y    = 4;
    localparam int C_D_Z    = 3;

    localparam int S_FLOW  = 7;
    localparam int S_BPA   = 6;
    localparam int S_BPB   = 5;
    localparam int S_ALONE = 4;
    localparam int S_BPD   = 3;
    localparam int S_FORCE = 1;
    localparam int S_OPC   = 0;

    localparam int STS_W = 8;
    localparam int NUM_BP = 4;
endpackage

// File: rtl/bpu_regfile.sv
module bpu_regfile
    import bpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_addr,
    input  logic [DW-1:0]              wr_data,
    output logic [NUM_BP-1:0][DW-1:0]  bp,
    output logic [DW-1:0]              ctrl
);
    localparam logic [DW-1:0] CTRL_WMASK = ~(DW'(3));

    typedef struct packed {
        logic [NUM_BP-1:0][DW-1:0] bp;
        logic [DW-1:0]             ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr < 4'(NUM_BP)) begin
                st_d.bp[wr_addr[1:0]] = wr_data;
            end else if (wr_addr == ADDR_CTRL) begin
                st_d.ctrl = wr_data & CTRL_WMASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp   = st_q.bp;
    assign ctrl = st_q.ctrl;
endmodule

// File: rtl/bpu_match.sv
module bpu_match
    import bpu_pkg::*;
#(
    parameter int          DW     = 16,
    parameter logic [15:0] BRK_OP = 16'h9598
) (
    input  logic                       fetch_valid,
    input  logic [DW-1:0]              fetch_pc,
    input  logic [15:0]                fetch_op,
    input  logic                       flow_chg,
    input  logic                       force_brk,
    input  logic [NUM_BP-1:0][DW-1:0]  bp,
    input  logic [DW-1:0]              ctrl,
    output logic [STS_W-1:0]           cause
);
    logic [DW-1:0]     ign_mask;
    logic [NUM_BP-1:0] hit;

    assign ign_mask = ctrl[C_MASK] ? bp[2] : '0;

    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        if (i == 2) begin : g_alone
            assign hit[i] = ctrl[C_EN_S] && fetch_valid && (fetch_pc == bp[i]);
        end else begin : g_prog
            logic en;
            if (i == 0) begin : g_a
                assign en = ctrl[C_EN_A];
            end else if (i == 1) begin : g_b
                assign en = ctrl[C_EN_B];
            end else begin : g_d
                assign en = ctrl[C_D_X] & ctrl[C_D_Y] & ctrl[C_D_Z];
            end
            assign hit[i] = en && fetch_valid &&
                            (((fetch_pc ^ bp[i]) & ~ign_mask) == '0);
        end
    end

    always_comb begin
        cause          = '0;
        cause[S_FLOW]  = ctrl[C_FLOW] & flow_chg;
        cause[S_BPA]   = hit[0];
        cause[S_BPB]   = hit[1];
        cause[S_ALONE] = hit[2];
        cause[S_BPD]   = hit[3];
        cause[S_FORCE] = force_brk;
        cause[S_OPC]   = fetch_valid && (fetch_op == BRK_OP);
    end
endmodule

// File: rtl/bpu_status.sv
module bpu_status
    import bpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] cause,
    input  logic             run_req,
    output logic             brk_req,
    output logic             halted,
    output logic [STS_W-1:0] status
);
    typedef struct packed {
        logic             brk;
        logic             halt;
        logic [STS_W-1:0] sts;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.brk = 1'b0;
        if (st_q.halt) begin
            if (run_req) begin
                st_d.halt = 1'b0;
                st_d.sts  = '0;
            end
        end else if (|cause) begin
            st_d.brk  = 1'b1;
            st_d.halt = 1'b1;
            st_d.sts  = st_q.sts | cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_req = st_q.brk;
    assign halted  = st_q.halt;
    assign status  = st_q.sts;
endmodule

// File: rtl/bpu_top.sv
module bpu_top
    import bpu_pkg::*;
#(
    parameter int          DW     = 16,
    parameter logic [15:0] BRK_OP = 16'h9598
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          fetch_valid,
    input  logic [DW-1:0] fetch_pc,
    input  logic [15:0]   fetch_op,
    input  logic          flow_chg,
    input  logic          force_brk,
    input  logic          run_req,
    output logic          brk_req,
    output logic          halted,
    output logic          timers_run
);
    logic [NUM_BP-1:0][DW-1:0] bp;
    logic [DW-1:0]             ctrl;
    logic [STS_W-1:0]          cause;
    logic [STS_W-1:0]          status;

    bpu_regfile #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .bp      (bp),
        .ctrl    (ctrl)
    );

    bpu_match #(.DW(DW), .BRK_OP(BRK_OP)) u_match (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .fetch_op    (fetch_op),
        .flow_chg    (flow_chg),
        .force_brk   (force_brk),
        .bp          (bp),
        .ctrl        (ctrl),
        .cause       (cause)
    );

    bpu_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause   (cause),
        .run_req (run_req),
        .brk_req (brk_req),
        .halted  (halted),
        .status  (status)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_BPA:  reg_rdata = bp[0];
            ADDR_BPB:  reg_rdata = bp[1];
            ADDR_MSK:  reg_rdata = bp[2];
            ADDR_BPD:  reg_rdata = bp[3];
            ADDR_CTRL: reg_rdata = ctrl;
            ADDR_STS:  reg_rdata = DW'(status);
            default:   reg_rdata = '0;
        endcase
    end

    assign timers_run = ~halted | ctrl[C_TIMERS];
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
    import bpu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       reg_addr,
    input logic [DW-1:0]    reg_rdata,
    input logic             force_brk,
    input logic             run_req,
    input logic [STS_W-1:0] cause,
    input logic [STS_W-1:0] status,
    input logic             brk_req,
    input logic             halted
);
    p_ctrl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (reg_rdata[1:0] == 2'b00));

    p_sts_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STS) |-> (reg_rdata[DW-1:8] == '0));

    p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && force_brk) |=> status[S_FORCE]);

    p_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && (cause != '0)) |=> (brk_req && halted));

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !run_req) |=> ($stable(status) && !brk_req && halted));

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run_req) |=> (!halted && (status == '0)));
endmodule

bind bpu_top bpu_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .force_brk (force_brk),
    .run_req   (run_req),
    .cause     (cause),
    .status    (status),
    .brk_req   (brk_req),
    .halted    (halted)
);

// File: tb/bpu_top_tb.sv
`timescale 1ns/1ps
module bpu_top_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          fetch_valid = 1'b0;
    logic [DW-1:0] fetch_pc = '0;
    logic [15:0]   fetch_op = '0;
    logic          flow_chg = 1'b0;
    logic          force_brk = 1'b0;
    logic          run_req = 1'b0;
    logic          brk_req, halted, timers_run;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_bp [4];
    logic [DW-1:0] m_ctrl;

    always #10 clk = ~clk;

    bpu_top #(.DW(DW)) u_dut (.*);

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < 4) m_bp[a[1:0]] = d;
        else if (a == 4'h8) m_ctrl = d & 16'hFFFC;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(input logic fv, input logic [DW-1:0] pc, input logic [15:0] op,
                       input logic fl, input logic fb, input logic rr);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_op = op;
        flow_chg = fl; force_brk = fb; run_req = rr;
        @(negedge clk);
        fetch_valid = 1'b0; flow_chg = 1'b0; force_brk = 1'b0; run_req = 1'b0;
    endtask

    function automatic logic [7:0] exp_cause(input logic fv, input logic [DW-1:0] pc,
                                              input logic [15:0] op, input logic fl,
                                              input logic fb);
        logic [7:0] c = '0;
        logic [DW-1:0] ig = m_ctrl[9] ? m_bp[2] : '0;
        c[7] = m_ctrl[13] & fl;
        c[6] = fv & m_ctrl[12] & (((pc ^ m_bp[0]) & ~ig) == 0);
        c[5] = fv & m_ctrl[11] & (((pc ^ m_bp[1]) & ~ig) == 0);
        c[4] = fv & m_ctrl[10] & (pc == m_bp[2]);
        c[3] = fv & m_ctrl[7] & m_ctrl[4] & m_ctrl[3] & (((pc ^ m_bp[3]) & ~ig) == 0);
        c[1] = fb;
        c[0] = fv & (op == 16'h9598);
        return c;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [DW-1:0] d;
        logic [7:0] ec;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 4; i++) m_bp[i] = '0;
        m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk(brk_req, 0, "R10 reset brk_req");
        chk(halted, 0, "R10 reset halted");
        chk(timers_run, 1, "R2 reset timers_run");
        rd(4'h9, d); chk(d, 0, "R3 reset status");

        // R1 readback and unmapped
        wr(4'h0, 16'h1234); wr(4'h1, 16'hABCD); wr(4'h2, 16'h00F0); wr(4'h3, 16'h8001);
        rd(4'h0, d); chk(d, 16'h1234, "R1 reg0");
        rd(4'h1, d); chk(d, 16'hABCD, "R1 reg1");
        rd(4'h2, d); chk(d, 16'h00F0, "R1 reg2");
        rd(4'h3, d); chk(d, 16'h8001, "R1 reg3");
        wr(4'h5, 16'hFFFF);
        rd(4'h5, d); chk(d, 0, "R1 unmapped");

        // R2 low control bits
        wr(4'h8, 16'h0003);
        rd(4'h8, d); chk(d, 0, "R2 ctrl low bits");

        // R3 status not writable
        wr(4'h9, 16'hFFFF);
        rd(4'h9, d); chk(d, 0, "R3 status write ignored");

        // R7 breakpoint D needs all three bits
        wr(4'h8, 16'h0090);
        cyc(1, 16'h8001, 16'h0000, 0, 0, 0);
        chk(brk_req, 0, "R7 two of three bits");
        wr(4'h8, 16'h0098);
        cyc(1, 16'h8001, 16'h0000, 0, 0, 0);
        chk(brk_req, 1, "R7 all three bits");
        chk(timers_run, 0, "R2 timers stop when halted");
        rd(4'h9, d); chk(d, 16'h0008, "R7 status bit3");
        // R11 ignored while halted
        cyc(0, 0, 0, 0, 1, 0);
        chk(brk_req, 0, "R11 no pulse when halted");
        rd(4'h9, d); chk(d, 16'h0008, "R11 status unchanged");
        cyc(0, 0, 0, 0, 0, 1);
        chk(halted, 0, "R12 halt cleared");
        rd(4'h9, d); chk(d, 0, "R12 status cleared");

        // R6 mask mode with breakpoint A, R2 timers bit
        wr(4'h8, 16'h9200);
        cyc(1, 16'h12C4, 16'h0000, 0, 0, 0);
        chk(brk_req, 1, "R6 masked match");
        chk(timers_run, 1, "R2 timers keep running");
        rd(4'h9, d); chk(d, 16'h0040, "R4 R6 status bit6");
        cyc(0, 0, 0, 0, 0, 1);
        wr(4'h8, 16'h1000);
        cyc(1, 16'h12C4, 16'h0000, 0, 0, 0);
        chk(brk_req, 0, "R6 no mask no match");

        // R5 standalone, R8 flow, R9 opcode together
        wr(4'h8, 16'h2400);
        cyc(1, 16'h00F0, 16'h9598, 1, 0, 0);
        chk(brk_req, 1, "R5 R8 R9 combined");
        rd(4'h9, d); chk(d, 16'h0091, "R5 R8 R9 combined status");
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 16'h00F0, 16'h0000, 1, 0, 0);
        rd(4'h9, d); chk(d, 16'h0080, "R8 flow without fetch");
        cyc(0, 0, 0, 0, 0, 1);

        // random mix
        for (int it = 0; it < 300; it++) begin
            logic [DW-1:0] pc;
            logic [15:0] op;
            logic fv, fl, fb;
            for (int k = 0; k < 4; k++) wr(4'(k), 16'($urandom));
            wr(4'h8, 16'($urandom));
            case ($urandom % 6)
                0: pc = m_bp[0];
                1: pc = m_bp[1];
                2: pc = m_bp[2];
                3: pc = m_bp[3];
                4: pc = m_bp[$urandom % 4] ^ (16'($urandom) & m_bp[2]);
                default: pc = 16'($urandom);
            endcase
            op = (($urandom % 8) == 0) ? 16'h9598 : 16'($urandom);
            fv = ($urandom % 4) != 0;
            fl = ($urandom % 4) == 0;
            fb = ($urandom % 8) == 0;
            ec = exp_cause(fv, pc, op, fl, fb);
            cyc(fv, pc, op, fl, fb, 0);
            chk(brk_req, ec != 0, "R4 R5 R6 R7 R8 R9 R10 random pulse");
            chk(halted, ec != 0, "R10 random halted");
            rd(4'h9, d); chk(d, {8'h00, ec}, "R4 R5 R6 R7 R8 R9 random status");
            if (ec != 0) begin
                cyc(1, m_bp[0], 16'h9598, 1, 1, 0);
                chk(brk_req, 0, "R11 random no pulse");
                rd(4'h9, d); chk(d, {8'h00, ec}, "R11 random status held");
                cyc(0, 0, 0, 0, 0, 1);
                chk(halted, 0, "R12 random resume");
                rd(4'h9, d); chk(d, 0, "R12 random status cleared");
            end
        end
        summary();
    end
endmodule